// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is a 32-pin general-purpose I/O port that sits behind a simple word-addressed register bus. Each pin has a direction bit, an output bit and a configuration byte with three enables: input buffer, pull resistor and peripheral routing. A pin whose routing enable is set gives up its port-controlled drive and pull. The pad then sees a 4-bit peripheral number taken from a nibble of a shared select byte, with two pins per byte. The pad-side outputs are output enable, output data, pull enable, pull direction, input buffer enable, routing enable and the peripheral number of each pin.

Pad levels reach the input register through a two-flop synchronizer per pin. The pins are split into four groups of eight. By default a group's synchronizers advance only while an input-register read is in flight, and that read then holds the bus ready low for two cycles. Setting a group's continuous-sampling bit keeps its flops running on every clock. When all four groups run continuously, an input read completes without a wait. Pull direction has no control bit of its own: on a non-driving pin with pull enabled, the output bit picks pull-up (1) or pull-down (0).

Top module: `gpio_port`

## Requirements
- R1: After the synchronous active-high reset, the direction, output, configuration, select and sampling registers all read 0, and every pin shows oe, out, pull_en, pull_up, ie and mux_en all 0 and psel 0.
- R2: The word map is fixed. Word 0 is direction and word 1 is output, one bit per pin with bit i for pin i. Word 2 is the input register; it is read-only and writes to it change nothing. Word 3 bits 3:0 are the sampling bits, with bit g covering pins 8g to 8g+7, and its other bits read 0. Non-input accesses complete in the cycle they are presented (ready high).
- R3: A read of word 2 while any sampling bit is 0 keeps bus_ready low for exactly two cycles. It then returns the pad levels that were present when the read began.
- R4: With all four sampling bits set, a read of word 2 completes with no wait. It returns the pad levels from two clock edges earlier.
- R5: Bit i of an input read is 0 whenever pin i's input-enable is 0.
- R6: A pin with direction 1 and routing disabled drives: oe=1, out equals its output bit, and pull_en=0 whatever its pull-enable is. Its ie follows its input-enable.
- R7: A pin with direction 0, routing disabled and pull-enable set has oe=0 and pull_en=1. Its pull_up equals its output bit (1 pull-up, 0 pull-down). Its ie follows its input-enable on its own.
- R8: A pin with direction 0 and input-enable, pull-enable and routing-enable all 0 has oe, out, pull_en, pull_up and ie all 0, whatever its output bit holds.
- R9: Configuration byte bit 0 is routing enable, bit 1 is input enable and bit 2 is pull enable; configuration bytes for pin i sit at word 4 + i/4, byte i%4. A pin with routing enabled has oe, out, pull_en and pull_up 0 and mux_en 1. Its psel is taken from select byte i/2 (word 12 + i/8, byte (i/2)%4): bits 3:0 for an even pin and bits 7:4 for an odd pin. psel is 0 on a pin with routing disabled.
- R10: Every register byte is written only when its byte strobe is set. Unstrobed bytes, including the neighbouring configuration and select bytes of other pins, keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Access request, held until bus_ready |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte write strobes |
| bus_rdata | output | 32 | Read data, valid while bus_ready |
| bus_ready | output | 1 | Access completes this cycle |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_oe | output | 32 | Output enable per pin |
| pad_out | output | 32 | Output data per pin |
| pad_pull_en | output | 32 | Pull resistor enable per pin |
| pad_pull_up | output | 32 | Pull direction per pin, 1 up |
| pad_ie | output | 32 | Input buffer enable per pin |
| pad_mux_en | output | 32 | Peripheral routing active per pin |
| pad_psel | output | 128 | Peripheral number, 4 bits per pin |

## Verification
The pad decode is driven with a mix of pins covering every row that matters at once. The mix has a driving pin with pull requested, non-driving pins pulling up and down, a fully disabled pin whose output bit is 1, and a routed pin that also has direction set. A wrong priority between routing, direction and pull therefore shows up on a specific pin. Input reads are taken with no sampling, partial sampling and full sampling, and the two wait cycles are counted in each case. A pad change placed right before a continuous-mode read separates the two-edge latency from a direct path. Single-strobe writes into configuration and select words confirm that a neighbour's byte or nibble stays intact.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PSEL_W = 4;

    // Word indices of the register map, derived from the pin count.
    function automatic int w_cfg0(input int npins);
        return 4 + 0 * npins;
    endfunction

    function automatic int w_mux0(input int npins);
        return 4 + npins / 4;
    endfunction

    function automatic int word_total(input int npins);
        return 4 + npins / 4 + npins / 8;
    endfunction

    // Low three bits of a configuration byte.
    typedef struct packed {
        logic pull_en;
        logic in_en;
        logic mux_en;
    } pin_cfg_t;

    typedef struct packed {
        logic oe;
        logic out;
        logic pull_en;
        logic pull_up;
        logic ie;
    } pad_ctl_t;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_STAGE = 2'd1,
        RD_DONE  = 2'd2
    } in_rd_e;

    function automatic pad_ctl_t decode_pad(input logic dir, input logic outv,
                                            input pin_cfg_t c);
        pad_ctl_t p;
        p    = '0;
        p.ie = c.in_en;
        if (!c.mux_en) begin
            if (dir) begin
                p.oe  = 1'b1;
                p.out = outv;
            end else begin
                p.pull_en = c.pull_en;
                p.pull_up = c.pull_en & outv;
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NPINS    = 32,
    parameter int GRP_SIZE = 8,
    parameter int WA       = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [WA-1:0]                  word,
    input  logic [31:0]                    wdata,
    input  logic [3:0]                     wstrb,
    output logic [NPINS-1:0]               dir_o,
    output logic [NPINS-1:0]               out_o,
    output pin_cfg_t [NPINS-1:0]           cfg_o,
    output logic [NPINS-1:0][PSEL_W-1:0]   psel_o,
    output logic [NPINS/GRP_SIZE-1:0]      smp_o,
    output logic [31:0]                    rdata
);
    localparam int GROUPS = NPINS / GRP_SIZE;
    localparam int CFGW   = NPINS / 4;
    localparam int MUXB   = NPINS / 2;
    localparam int MUXW   = NPINS / 8;
    localparam int WCFG   = w_cfg0(NPINS);
    localparam int WMUX   = w_mux0(NPINS);

    logic [NPINS-1:0]     dir_q, out_q;
    logic [7:0]           cfg_q [NPINS];
    logic [7:0]           mux_q [MUXB];
    logic [GROUPS-1:0]    smp_q;
    logic [31:0]          cfg_words [CFGW];
    logic [31:0]          mux_words [MUXW];

    // Direction and output bytes
    for (genvar b = 0; b < NPINS / 8; b++) begin : g_io_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                dir_q[8*b +: 8] <= '0;
                out_q[8*b +: 8] <= '0;
            end else if (wr_en && wstrb[b]) begin
                if (word == WA'(0)) dir_q[8*b +: 8] <= wdata[8*b +: 8];
                if (word == WA'(1)) out_q[8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) smp_q <= '0;
        else if (wr_en && wstrb[0] && word == WA'(3)) smp_q <= wdata[GROUPS-1:0];
    end

    // One configuration byte per pin
    for (genvar i = 0; i < NPINS; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst) cfg_q[i] <= '0;
            else if (wr_en && wstrb[i % 4] && word == WA'(WCFG + i / 4))
                cfg_q[i] <= wdata[8*(i % 4) +: 8];
        end
        assign cfg_o[i] = pin_cfg_t'(cfg_q[i][2:0]);
        assign cfg_words[i / 4][8*(i % 4) +: 8] = cfg_q[i];
        assign psel_o[i] = mux_q[i / 2][PSEL_W*(i % 2) +: PSEL_W];
    end

    // One select byte per pin pair
    for (genvar k = 0; k < MUXB; k++) begin : g_mux
        always_ff @(posedge clk) begin
            if (rst) mux_q[k] <= '0;
            else if (wr_en && wstrb[k % 4] && word == WA'(WMUX + k / 4))
                mux_q[k] <= wdata[8*(k % 4) +: 8];
        end
        assign mux_words[k / 4][8*(k % 4) +: 8] = mux_q[k];
    end

    always_comb begin
        rdata = '0;
        if (word == WA'(0)) rdata = dir_q;
        if (word == WA'(1)) rdata = out_q;
        if (word == WA'(3)) rdata = 32'(smp_q);
        for (int w = 0; w < CFGW; w++)
            if (word == WA'(WCFG + w)) rdata = cfg_words[w];
        for (int w = 0; w < MUXW; w++)
            if (word == WA'(WMUX + w)) rdata = mux_words[w];
    end

    assign dir_o = dir_q;
    assign out_o = out_q;
    assign smp_o = smp_q;

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dir_q == '0 && out_q == '0 && smp_q == '0));

    a_r10_neighbour_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && word == WA'(WCFG) && !wstrb[1]) |=> $stable(cfg_q[1]));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS    = 32,
    parameter int GRP_SIZE = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NPINS-1:0]          pad_in,
    input  logic [NPINS/GRP_SIZE-1:0] grp_cont,
    input  logic                      demand,
    output logic [NPINS-1:0]          sync_o
);
    localparam int GROUPS = NPINS / GRP_SIZE;

    logic [NPINS-1:0] s1, s2;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic adv;
        assign adv = grp_cont[g] | demand;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1[g*GRP_SIZE +: GRP_SIZE] <= '0;
                s2[g*GRP_SIZE +: GRP_SIZE] <= '0;
            end else if (adv) begin
                s1[g*GRP_SIZE +: GRP_SIZE] <= pad_in[g*GRP_SIZE +: GRP_SIZE];
                s2[g*GRP_SIZE +: GRP_SIZE] <= s1[g*GRP_SIZE +: GRP_SIZE];
            end
        end

        a_r4_two_edge_latency: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(rst, 2) && $past(adv) && $past(adv, 2))
            |-> (s2[g*GRP_SIZE +: GRP_SIZE] == $past(pad_in[g*GRP_SIZE +: GRP_SIZE], 2)));
    end

    assign sync_o = s2;

endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import gpio_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0]             dir,
    input  logic [NPINS-1:0]             outv,
    input  pin_cfg_t [NPINS-1:0]         cfg,
    input  logic [NPINS-1:0][PSEL_W-1:0] psel,
    output logic [NPINS-1:0]             pad_oe,
    output logic [NPINS-1:0]             pad_out,
    output logic [NPINS-1:0]             pad_pull_en,
    output logic [NPINS-1:0]             pad_pull_up,
    output logic [NPINS-1:0]             pad_ie,
    output logic [NPINS-1:0]             pad_mux_en,
    output logic [NPINS*PSEL_W-1:0]      pad_psel
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pad_ctl_t p;
        assign p              = decode_pad(dir[i], outv[i], cfg[i]);
        assign pad_oe[i]      = p.oe;
        assign pad_out[i]     = p.out;
        assign pad_pull_en[i] = p.pull_en;
        assign pad_pull_up[i] = p.pull_up;
        assign pad_ie[i]      = p.ie;
        assign pad_mux_en[i]  = cfg[i].mux_en;
        assign pad_psel[i*PSEL_W +: PSEL_W] = cfg[i].mux_en ? psel[i] : '0;

        always_comb begin
            a_r6_drive_no_pull: assert (!(pad_oe[i] && pad_pull_en[i]));
            a_r7_pull_dir_needs_pull: assert (!pad_pull_up[i] || pad_pull_en[i]);
            a_r9_routed_port_quiet: assert (!(pad_mux_en[i] && (pad_oe[i] || pad_pull_en[i] || pad_out[i])));
            a_r8_idle_out_low: assert (pad_oe[i] || !pad_out[i]);
        end
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NPINS    = 32,
    parameter int GRP_SIZE = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic [3:0]               bus_addr,
    input  logic [31:0]              bus_wdata,
    input  logic [3:0]               bus_wstrb,
    output logic [31:0]              bus_rdata,
    output logic                     bus_ready,
    input  logic [NPINS-1:0]         pad_in,
    output logic [NPINS-1:0]         pad_oe,
    output logic [NPINS-1:0]         pad_out,
    output logic [NPINS-1:0]         pad_pull_en,
    output logic [NPINS-1:0]         pad_pull_up,
    output logic [NPINS-1:0]         pad_ie,
    output logic [NPINS-1:0]         pad_mux_en,
    output logic [NPINS*PSEL_W-1:0]  pad_psel
);
    localparam int GROUPS = NPINS / GRP_SIZE;
    localparam int WA     = $clog2(word_total(NPINS));
    localparam logic [WA-1:0] W_IN = WA'(2);

    logic [NPINS-1:0]             dir_q, out_q, sync_q;
    pin_cfg_t [NPINS-1:0]         cfg_q;
    logic [NPINS-1:0][PSEL_W-1:0] psel_q;
    logic [GROUPS-1:0]            smp_q;
    logic [31:0]                  reg_rdata;
    logic                         is_in_rd, all_cont, demand;
    in_rd_e                       rd_st;

    gpio_regs #(.NPINS(NPINS), .GRP_SIZE(GRP_SIZE), .WA(WA)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_valid & bus_write),
        .word  (bus_addr),
        .wdata (bus_wdata),
        .wstrb (bus_wstrb),
        .dir_o (dir_q),
        .out_o (out_q),
        .cfg_o (cfg_q),
        .psel_o(psel_q),
        .smp_o (smp_q),
        .rdata (reg_rdata)
    );

    gpio_in_sync #(.NPINS(NPINS), .GRP_SIZE(GRP_SIZE)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pad_in  (pad_in),
        .grp_cont(smp_q),
        .demand  (demand),
        .sync_o  (sync_q)
    );

    gpio_pad_ctl #(.NPINS(NPINS)) u_pad (
        .dir        (dir_q),
        .outv       (out_q),
        .cfg        (cfg_q),
        .psel       (psel_q),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up),
        .pad_ie     (pad_ie),
        .pad_mux_en (pad_mux_en),
        .pad_psel   (pad_psel)
    );

    // On-demand input read sequencing
    assign is_in_rd = bus_valid && !bus_write && bus_addr == W_IN;
    assign all_cont = &smp_q;
    assign demand   = is_in_rd && !all_cont && rd_st != RD_DONE;

    always_ff @(posedge clk) begin
        if (rst)                   rd_st <= RD_IDLE;
        else if (demand)           rd_st <= (rd_st == RD_IDLE) ? RD_STAGE : RD_DONE;
        else                       rd_st <= RD_IDLE;
    end

    assign bus_ready = !is_in_rd || all_cont || rd_st == RD_DONE;
    assign bus_rdata = (bus_addr == W_IN) ? (sync_q & pad_ie) : reg_rdata;

    a_r3_wait_held: assert property (@(posedge clk) disable iff (rst)
        (is_in_rd && !all_cont && bus_ready) |-> ($past(bus_valid) && $past(bus_valid, 2)));

    a_r5_in_masked: assert property (@(posedge clk) disable iff (rst)
        (is_in_rd && bus_ready) |-> ((bus_rdata & ~pad_ie) == '0));

endmodule

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]   bus_addr = '0, bus_wstrb = '0;
    logic [31:0]  bus_wdata = '0, bus_rdata;
    logic         bus_ready;
    logic [31:0]  pad_in = '0;
    logic [31:0]  pad_oe, pad_out, pad_pull_en, pad_pull_up, pad_ie, pad_mux_en;
    logic [127:0] pad_psel;

    always #2 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up), .pad_ie(pad_ie), .pad_mux_en(pad_mux_en),
        .pad_psel(pad_psel)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference state kept from the requirements
    logic [31:0] dir_m, out_m;
    logic [7:0]  cfg_m [32];
    logic [7:0]  mux_m [16];
    logic [3:0]  smp_m;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        dir_m = '0; out_m = '0; smp_m = '0;
        for (int i = 0; i < 32; i++) cfg_m[i] = '0;
        for (int k = 0; k < 16; k++) mux_m[k] = '0;
    endtask

    function automatic logic [31:0] ie_mask();
        logic [31:0] m;
        for (int i = 0; i < 32; i++) m[i] = cfg_m[i][1];
        return m;
    endfunction

    function automatic logic [31:0] cfg_word(input int w);
        return {cfg_m[4*w+3], cfg_m[4*w+2], cfg_m[4*w+1], cfg_m[4*w]};
    endfunction

    // Monitor: every completed read is compared with the head of the queue
    always @(negedge clk) begin
        if (!rst && bus_valid && !bus_write && bus_ready) begin
            if (exp_q.size() == 0) begin
                chk(bus_rdata, 128'h0, "R2 unexpected read completion");
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic wr(input int w, input logic [31:0] d, input logic [3:0] s);
        for (int b = 0; b < 4; b++) begin
            if (s[b]) begin
                if (w == 0) dir_m[8*b +: 8] = d[8*b +: 8];
                if (w == 1) out_m[8*b +: 8] = d[8*b +: 8];
                if (w == 3 && b == 0) smp_m = d[3:0];
                if (w >= 4 && w < 12) cfg_m[(w-4)*4+b] = d[8*b +: 8];
                if (w >= 12 && w < 16) mux_m[(w-12)*4+b] = d[8*b +: 8];
            end
        end
        bus_valid = 1; bus_write = 1; bus_addr = 4'(w); bus_wdata = d; bus_wstrb = s;
        @(negedge clk);
        chk({127'b0, bus_ready}, 128'h1, "R2 write ready");
        @(posedge clk); #1;
        bus_valid = 0; bus_write = 0; bus_wstrb = '0;
    endtask

    task automatic rd(input int w, input logic [31:0] exp, input int exp_stall, input string tag);
        int stall = 0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_valid = 1; bus_write = 0; bus_addr = 4'(w);
        @(negedge clk);
        while (!bus_ready && stall < 10) begin
            stall++;
            @(negedge clk);
        end
        @(posedge clk); #1;
        bus_valid = 0;
        chk(128'(stall), 128'(exp_stall), {tag, " wait cycles"});
    endtask

    task automatic check_pads(input string tag);
        logic [31:0]  e_oe, e_out, e_pe, e_pu, e_ie, e_mx;
        logic [127:0] e_ps;
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            logic mx, ie, pe;
            mx = cfg_m[i][0]; ie = cfg_m[i][1]; pe = cfg_m[i][2];
            e_oe[i]  = !mx && dir_m[i];
            e_out[i] = !mx && dir_m[i] && out_m[i];
            e_pe[i]  = !mx && !dir_m[i] && pe;
            e_pu[i]  = !mx && !dir_m[i] && pe && out_m[i];
            e_ie[i]  = ie;
            e_mx[i]  = mx;
            e_ps[4*i +: 4] = mx ? ((i % 2) ? mux_m[i/2][7:4] : mux_m[i/2][3:0]) : 4'h0;
        end
        chk(pad_oe,      e_oe,  {tag, " oe (R6 R9)"});
        chk(pad_out,     e_out, {tag, " out (R6 R8)"});
        chk(pad_pull_en, e_pe,  {tag, " pull_en (R7 R6)"});
        chk(pad_pull_up, e_pu,  {tag, " pull_up (R7)"});
        chk(pad_ie,      e_ie,  {tag, " ie (R7 R8)"});
        chk(pad_mux_en,  e_mx,  {tag, " mux_en (R9)"});
        chk(pad_psel,    e_ps,  {tag, " psel (R9)"});
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        #1 rst = 0;

        // R1: reset state
        check_pads("R1 reset");
        @(posedge clk); #1;
        rd(0,  32'h0, 0, "R1 dir after reset");
        rd(1,  32'h0, 0, "R1 out after reset");
        rd(3,  32'h0, 0, "R1 sampling after reset");
        rd(4,  32'h0, 0, "R1 cfg word after reset");
        rd(12, 32'h0, 0, "R1 select word after reset");

        // Mixed pin set: R6 R7 R8 R9
        wr(4,  32'h0204_0402, 4'hF);
        wr(5,  32'h0600_0104, 4'hF);
        wr(1,  32'h0000_004A, 4'hF);
        wr(0,  32'h0000_0038, 4'hF);
        wr(12, 32'h00A3_0000, 4'hF);
        check_pads("R6 R7 R8 R9 mixed");
        @(posedge clk); #1;
        rd(5, cfg_word(1), 0, "R9 cfg readback");
        rd(1, 32'h0000_004A, 0, "R2 out readback");

        // R10: single-byte strobes keep neighbours
        wr(5,  32'hFFFF_05FF, 4'b0010);
        wr(12, 32'hFF5C_FFFF, 4'b0100);
        check_pads("R10 strobe");
        @(posedge clk); #1;
        rd(5,  32'h0600_0504, 0, "R10 cfg neighbours kept");
        rd(12, 32'h005C_0000, 0, "R10 select neighbours kept");
        wr(0, 32'hFFFF_FF00, 4'b1110);
        rd(0, 32'hFFFF_FF38, 0, "R10 dir low byte kept");
        check_pads("R6 wide drive");
        @(posedge clk); #1;
        wr(0, 32'h0000_0038, 4'hF);

        // R2: input word is read-only
        wr(2, 32'hFFFF_FFFF, 4'hF);
        rd(0, 32'h0000_0038, 0, "R2 input write ignored dir");
        rd(1, 32'h0000_004A, 0, "R2 input write ignored out");

        // R3 R5: on-demand reads
        wr(6, 32'h0202_0202, 4'hF);
        wr(7, 32'h0202_0202, 4'hF);
        pad_in = 32'hDEAD_BEEF;
        @(posedge clk); #1;
        rd(2, 32'hDEAD_BEEF & ie_mask(), 2, "R3 R5 on-demand read");
        pad_in = 32'h1234_5678;
        rd(2, 32'h1234_5678 & ie_mask(), 2, "R3 fresh capture");
        wr(3, 32'h0000_0001, 4'hF);
        rd(3, 32'h0000_0001, 0, "R2 sampling readback");
        pad_in = 32'hFFFF_FFFF;
        rd(2, 32'hFFFF_FFFF & ie_mask(), 2, "R3 partial sampling still waits");

        // R4: continuous sampling on all groups
        wr(3, 32'hFFFF_FFFF, 4'hF);
        rd(3, 32'h0000_000F, 0, "R2 sampling upper bits read 0");
        pad_in = 32'h0F0F_00F0;
        repeat (3) @(posedge clk);
        #1;
        rd(2, 32'h0F0F_00F0 & ie_mask(), 0, "R4 continuous read");
        pad_in = 32'hFFFF_FFFF;
        rd(2, 32'h0F0F_00F0 & ie_mask(), 0, "R4 two-edge latency old value");
        @(posedge clk); #1;
        rd(2, 32'hFFFF_FFFF & ie_mask(), 0, "R4 new value after two edges");

        // R1: reset again from a busy state
        rst = 1;
        repeat (2) @(posedge clk);
        #1 rst = 0;
        model_reset();
        check_pads("R1 second reset");
        @(posedge clk); #1;
        rd(3, 32'h0, 0, "R1 sampling cleared");
        rd(2, 32'h0, 2, "R1 R5 input masked after reset");

        repeat (2) @(posedge clk);
        chk(128'(exp_q.size()), 128'h0, "R2 all reads completed");
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule